// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves parallel data between two bidirectional buses, called A and B. Each direction has a holding register with its own clock. The A-to-B register samples the A side and the B-to-A register samples the B side. Each register captures on the rising edge of its clock, whatever the select and enable lines are set to.

On each side a select input picks what that side drives:
- the live word now on the opposite bus, or
- the word held in the register for that direction.

Enables are separate for each side. The B side is enabled by a high level and the A side by a low level.

Each bus appears as three signals: a data-in vector, a data-out vector and a single output-enable bit. The surrounding fabric resolves these into the physical net. When both sides drive in live mode, each bus reinforces the other. Once every outside driver lets go, both buses hold their last value.

Top module: `bus_xfer_regd`

## Requirements
- R1: On a rising edge of `clk_ab` the A-to-B register loads `a_in`, and on a rising edge of `clk_ba` the B-to-A register loads `b_in`. This happens at any setting of the selects and enables.
- R2: `b_out` equals `a_in` while `sel_ab_stored` is 0. It equals the A-to-B register while `sel_ab_stored` is 1.
- R3: `a_out` equals `b_in` while `sel_ba_stored` is 0. It equals the B-to-A register while `sel_ba_stored` is 1.
- R4: `b_oe` is 1 exactly when `en_b` is 1, and `a_oe` is 1 exactly when `en_a_n` is 0. With `en_b`=0 and `en_a_n`=1 neither side drives.
- R5: The path never inverts or reorders bits. Bit k of a driven output equals bit k of its selected source.
- R6: With both sides enabled and both selects at 1, A shows the B-to-A register and B shows the A-to-B register at the same time.
- R7: With both sides enabled and both selects at 0, a word put on either bus appears on the other. After all outside drivers release, both buses keep that word.
- R8: While `rst_n` is 0, a rising edge of a register's clock clears that register to all zeros.
- R9: A register keeps its contents across edges of the other direction's clock and across changes on its own input between its own edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| rst_n | input | 1 | Synchronous active-low clear of both registers |
| sel_ab_stored | input | 1 | 1: B drives held word; 0: B drives live A |
| sel_ba_stored | input | 1 | 1: A drives held word; 0: A drives live B |
| en_b | input | 1 | Active-high enable of the B side |
| en_a_n | input | 1 | Active-low enable of the A side |
| a_in | input | WIDTH | Resolved value of the A bus |
| a_out | output | WIDTH | Word offered to the A bus |
| a_oe | output | 1 | A side drives when 1 |
| b_in | input | WIDTH | Resolved value of the B bus |
| b_out | output | WIDTH | Word offered to the B bus |
| b_oe | output | 1 | B side drives when 1 |

## Verification
Capture into a register and display on the far side can fall in the same cycle. A clock edge loads a new word while that direction's select is in stored mode. The output must still show the old word before the edge and the new word only after it.

The bench provokes this by changing the bus data and the select between clock pulses. It samples both sides of each edge against an independent model of the two registers.

Bus contention and bus hold also coincide whenever both sides are enabled in live mode. The bench's own resolver compares every enabled output with the outside driver. It then checks that the resolved buses keep their value once that driver lets go.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

   typedef enum logic {
      SRC_LIVE = 1'b0,
      SRC_HELD = 1'b1
   } src_sel_e;

   localparam int unsigned DIR_COUNT = 2;

endpackage

// File: rtl/xfer_store_reg.sv
module xfer_store_reg #(
   parameter int unsigned         WIDTH  = 8,
   parameter bit                  RST_EN = 1'b1,
   parameter logic [WIDTH-1:0]    RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1) begin : g_bad_width
      $error("xfer_store_reg: WIDTH must be at least 1");
   end

   if (RST_EN) begin : g_sync_clear
      always_ff @(posedge clk) begin
         if (!rst_n) q <= RST_VAL;
         else        q <= d;
      end
   end else begin : g_free_run
      logic unused_rst;
      assign unused_rst = rst_n;
      always_ff @(posedge clk) begin
         q <= d;
      end
   end

endmodule

// File: rtl/xfer_lane.sv
module xfer_lane
   import xfer_pkg::*;
#(
   parameter int unsigned WIDTH      = 8,
   parameter bit          ENABLE_LOW = 1'b0
) (
   input  src_sel_e         src,
   input  logic [WIDTH-1:0] live_word,
   input  logic [WIDTH-1:0] held_word,
   input  logic             enable_pin,
   output logic [WIDTH-1:0] drive_word,
   output logic             drive_on
);

   if (WIDTH < 1) begin : g_bad_width
      $error("xfer_lane: WIDTH must be at least 1");
   end

   always_comb begin
      unique case (src)
         SRC_HELD: drive_word = held_word;
         default:  drive_word = live_word;
      endcase
   end

   if (ENABLE_LOW) begin : g_en_low
      assign drive_on = ~enable_pin;
   end else begin : g_en_high
      assign drive_on = enable_pin;
   end

endmodule

// File: rtl/bus_xfer_regd.sv
module bus_xfer_regd
   import xfer_pkg::*;
#(
   parameter int unsigned      WIDTH   = 8,
   parameter bit               RST_EN  = 1'b1,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk_ab,
   input  logic             clk_ba,
   input  logic             rst_n,
   input  logic             sel_ab_stored,
   input  logic             sel_ba_stored,
   input  logic             en_b,
   input  logic             en_a_n,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic             a_oe,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic             b_oe
);

   localparam int unsigned MSB = WIDTH - 1;

   if (WIDTH < 1 || WIDTH > 1024) begin : g_bad_width
      $error("bus_xfer_regd: WIDTH out of range");
   end
   if (DIR_COUNT != 2) begin : g_bad_dirs
      $error("bus_xfer_regd: exactly two directions expected");
   end

   logic [MSB:0] held_ab;
   logic [MSB:0] held_ba;

   xfer_store_reg #(
      .WIDTH  (WIDTH),
      .RST_EN (RST_EN),
      .RST_VAL(RST_VAL)
   ) u_reg_ab (
      .clk  (clk_ab),
      .rst_n(rst_n),
      .d    (a_in),
      .q    (held_ab)
   );

   xfer_store_reg #(
      .WIDTH  (WIDTH),
      .RST_EN (RST_EN),
      .RST_VAL(RST_VAL)
   ) u_reg_ba (
      .clk  (clk_ba),
      .rst_n(rst_n),
      .d    (b_in),
      .q    (held_ba)
   );

   xfer_lane #(
      .WIDTH     (WIDTH),
      .ENABLE_LOW(1'b0)
   ) u_lane_b (
      .src       (src_sel_e'(sel_ab_stored)),
      .live_word (a_in),
      .held_word (held_ab),
      .enable_pin(en_b),
      .drive_word(b_out),
      .drive_on  (b_oe)
   );

   xfer_lane #(
      .WIDTH     (WIDTH),
      .ENABLE_LOW(1'b1)
   ) u_lane_a (
      .src       (src_sel_e'(sel_ba_stored)),
      .live_word (b_in),
      .held_word (held_ba),
      .enable_pin(en_a_n),
      .drive_word(a_out),
      .drive_on  (a_oe)
   );

endmodule

// File: rtl/xfer_chk.sv
module xfer_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic             clk_ab,
   input logic             clk_ba,
   input logic             rst_n,
   input logic             sel_ab_stored,
   input logic             sel_ba_stored,
   input logic             en_b,
   input logic             en_a_n,
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] a_out,
   input logic             a_oe,
   input logic [WIDTH-1:0] b_in,
   input logic [WIDTH-1:0] b_out,
   input logic             b_oe
);

   // R1 / R2: word sampled at one clk_ab edge is shown on B at the next
   p_cap_ab_r1: assert property (@(posedge clk_ab) disable iff (!rst_n)
      rst_n |=> (!sel_ab_stored || b_out == $past(a_in)));

   // R1 / R3: same for the B-to-A direction
   p_cap_ba_r1: assert property (@(posedge clk_ba) disable iff (!rst_n)
      rst_n |=> (!sel_ba_stored || a_out == $past(b_in)));

   p_live_ab_r2: assert property (@(posedge clk_ab) disable iff (!rst_n)
      !sel_ab_stored |-> (b_out == a_in));

   p_live_ba_r3: assert property (@(posedge clk_ba) disable iff (!rst_n)
      !sel_ba_stored |-> (a_out == b_in));

   p_oe_pol_r4: assert property (@(posedge clk_ab) disable iff (!rst_n)
      (b_oe == en_b) && (a_oe == !en_a_n));

endmodule

bind bus_xfer_regd xfer_chk #(.WIDTH(WIDTH)) u_chk (
   .clk_ab       (clk_ab),
   .clk_ba       (clk_ba),
   .rst_n        (rst_n),
   .sel_ab_stored(sel_ab_stored),
   .sel_ba_stored(sel_ba_stored),
   .en_b         (en_b),
   .en_a_n       (en_a_n),
   .a_in         (a_in),
   .a_out        (a_out),
   .a_oe         (a_oe),
   .b_in         (b_in),
   .b_out        (b_out),
   .b_oe         (b_oe)
);

// File: tb/sim_bus_xfer_regd.sv
module sim_bus_xfer_regd;

   localparam int W          = 8;
   localparam int CLK_PERIOD = 10;

   logic          clk_ab = 1'b0, clk_ba = 1'b0, rst_n = 1'b0;
   logic          sel_ab_stored = 1'b0, sel_ba_stored = 1'b0;
   logic          en_b = 1'b0, en_a_n = 1'b1;
   logic [W-1:0]  bus_a = '0, bus_b = '0;
   logic [W-1:0]  a_out, b_out;
   logic          a_oe, b_oe;

   logic          ext_a_en = 1'b0, ext_b_en = 1'b0;
   logic [W-1:0]  ext_a = '0, ext_b = '0;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   bus_xfer_regd #(.WIDTH(W)) u0 (
      .clk_ab       (clk_ab),
      .clk_ba       (clk_ba),
      .rst_n        (rst_n),
      .sel_ab_stored(sel_ab_stored),
      .sel_ba_stored(sel_ba_stored),
      .en_b         (en_b),
      .en_a_n       (en_a_n),
      .a_in         (bus_a),
      .a_out        (a_out),
      .a_oe         (a_oe),
      .b_in         (bus_b),
      .b_out        (b_out),
      .b_oe         (b_oe)
   );

   task automatic check(input string what, input logic [W-1:0] got, input logic [W-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", what, got, exp);
      end
   endtask

   // bus resolver with keeper: outside driver, else block, else last value
   task automatic settle();
      logic [W-1:0] na, nb;
      for (int i = 0; i < 4; i++) begin
         #1;
         na = ext_a_en ? ext_a : (a_oe ? a_out : bus_a);
         nb = ext_b_en ? ext_b : (b_oe ? b_out : bus_b);
         if (i == 3) begin
            if (ext_a_en && a_oe) check("R4 contention on A", a_out, ext_a);
            if (ext_b_en && b_oe) check("R4 contention on B", b_out, ext_b);
         end
         bus_a = na;
         bus_b = nb;
      end
      #1;
   endtask

   task automatic pulse_ab();
      clk_ab = 1'b1; #(CLK_PERIOD/2);
      clk_ab = 1'b0; #(CLK_PERIOD/2);
   endtask

   task automatic pulse_ba();
      clk_ba = 1'b1; #(CLK_PERIOD/2);
      clk_ba = 1'b0; #(CLK_PERIOD/2);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      total++;
      bad++;
      $display("FAIL watchdog got=%h exp=%h", 1'b1, 1'b0);
      finish_run();
   end

   initial begin
      // reset: R8
      ext_a_en = 1'b1; ext_a = 8'hFF;
      ext_b_en = 1'b1; ext_b = 8'hEE;
      settle();
      rst_n = 1'b0;
      pulse_ab(); pulse_ba();
      rst_n = 1'b1;
      ext_a_en = 1'b0; ext_b_en = 1'b0;
      sel_ab_stored = 1'b1; sel_ba_stored = 1'b1;
      en_b = 1'b1; en_a_n = 1'b0;
      settle();
      check("R8 A-to-B cleared", b_out, '0);
      check("R8 B-to-A cleared", a_out, '0);
      check("R4 both enabled b_oe", {7'd0, b_oe}, 8'd1);
      check("R4 both enabled a_oe", {7'd0, a_oe}, 8'd1);
      en_b = 1'b0; en_a_n = 1'b1;
      settle();
      check("R4 isolated b_oe", {7'd0, b_oe}, 8'd0);
      check("R4 isolated a_oe", {7'd0, a_oe}, 8'd0);

      // sweep A-to-B: R1 R2 R5 R4
      for (int v = 0; v < 256; v++) begin
         en_a_n = 1'b1; en_b = v[0]; sel_ab_stored = v[2];
         ext_b_en = 1'b0; ext_a_en = 1'b1; ext_a = v[W-1:0];
         settle();
         pulse_ab();
         ext_a = ~v[W-1:0];
         sel_ab_stored = 1'b1;
         settle();
         check("R1 A-to-B capture", b_out, v[W-1:0]);
         sel_ab_stored = 1'b0;
         settle();
         check("R2 R5 live A on B", b_out, ~v[W-1:0]);
         check("R4 b_oe follows en_b", {7'd0, b_oe}, {7'd0, v[0]});
      end

      // sweep B-to-A: R1 R3 R5 R4
      for (int v = 0; v < 256; v++) begin
         en_b = 1'b0; en_a_n = v[0]; sel_ba_stored = v[2];
         ext_a_en = 1'b0; ext_b_en = 1'b1; ext_b = v[W-1:0];
         settle();
         pulse_ba();
         ext_b = {v[3:0], v[7:4]};
         sel_ba_stored = 1'b1;
         settle();
         check("R1 B-to-A capture", a_out, v[W-1:0]);
         sel_ba_stored = 1'b0;
         settle();
         check("R3 R5 live B on A", a_out, {v[3:0], v[7:4]});
         check("R4 a_oe follows en_a_n", {7'd0, a_oe}, {7'd0, ~v[0]});
      end

      // R9: each register undisturbed by the other clock and by input churn
      en_b = 1'b0; en_a_n = 1'b1;
      ext_a_en = 1'b1; ext_a = 8'h5A; ext_b_en = 1'b1; ext_b = 8'hA5;
      settle(); pulse_ab(); pulse_ba();
      for (int k = 0; k < 4; k++) begin
         ext_a = 8'h11 * k[7:0]; ext_b = 8'h22 + k[7:0];
         settle(); pulse_ba();
      end
      sel_ab_stored = 1'b1;
      settle();
      check("R9 A-to-B held across clk_ba", b_out, 8'h5A);
      ext_b = 8'h77; settle(); pulse_ab();
      sel_ba_stored = 1'b1;
      ext_b = 8'h00; settle();
      check("R9 B-to-A held across clk_ab", a_out, 8'h25);

      // R6: simultaneous stored display on both sides
      ext_a = 8'h3C; ext_b = 8'hC3;
      settle(); pulse_ab(); pulse_ba();
      ext_a_en = 1'b0; ext_b_en = 1'b0;
      en_b = 1'b1; en_a_n = 1'b0;
      sel_ab_stored = 1'b1; sel_ba_stored = 1'b1;
      settle();
      check("R6 A bus shows B-to-A", bus_a, 8'hC3);
      check("R6 B bus shows A-to-B", bus_b, 8'h3C);

      // R7: live loop with bus hold
      sel_ab_stored = 1'b0; sel_ba_stored = 1'b0;
      ext_a_en = 1'b1; ext_a = 8'h96;
      settle();
      check("R7 B follows driven A", bus_b, 8'h96);
      ext_a_en = 1'b0;
      settle(); settle();
      check("R7 A holds after release", bus_a, 8'h96);
      check("R7 B holds after release", bus_b, 8'h96);
      ext_b_en = 1'b1; ext_b = 8'h21;
      settle();
      check("R7 A follows driven B", bus_a, 8'h21);
      ext_b_en = 1'b0;
      settle(); settle();
      check("R7 A holds second word", bus_a, 8'h21);
      check("R7 B holds second word", bus_b, 8'h21);

      // R8 again: clear while holding data
      rst_n = 1'b0; pulse_ab(); rst_n = 1'b1;
      sel_ab_stored = 1'b1; en_a_n = 1'b1;
      settle();
      check("R8 clear by clk_ab edge", b_out, '0);

      finish_run();
   end

endmodule